// File: doc/BRIEF.md
# Four-Lane 7:1 Video Serializer

This block takes a 28-bit parallel pixel word once per pixel period and sends it out over four serial data lanes, seven bits per lane per pixel. A fifth lane carries a forwarded clock at the pixel rate, so the receiving side can frame the slices. The block runs on a bit clock at seven times the pixel rate, supplied from outside and phase-aligned with the pixel clock. The pixel clock is sampled as a level in the bit-clock domain. A configuration input chooses which pixel-clock edge captures the word.

Every captured word goes into a staging register. A load strobe from a modulo-7 slot counter moves it into the per-lane shift registers, so only whole words are ever sent. An active-low power-down input clears every register and forces all five lanes low while it is held. After release, nothing is sent before the first whole word boundary that follows a capture.

Top module: `s7_video_serializer`

## Requirements
- R1: Lane L (L = 0..3) carries input bits 7L+6 down to 7L. Lane 0 takes bits 0–6, lane 1 bits 7–13, lane 2 bits 14–20 and lane 3 bits 21–27.
- R2: With `edge_sel` = 1 the word is captured on a rising pixel-clock edge. With `edge_sel` = 0 it is captured on a falling edge. Data present only around the other edge is never sent.
- R3: Each data lane sends one 7-bit slice per pixel period, one bit per bit-clock cycle, highest-numbered bit of its group first.
- R4: The clock lane sends the pattern 1,1,0,0,0,1,1 (in time order) every pixel period. Its first bit coincides with the first bit of each data slice, so frames recur exactly every 7 bit cycles.
- R5: While `pwdn_n` is 0, all four data lanes and the clock lane read 0 and every internal register is cleared.
- R6: After `pwdn_n` rises, all lanes stay 0 for at least the first six bit-clock cycles. Output then starts only at a slot-counter wrap, with a complete word and a complete clock pattern.
- R7: Every word presented for one pixel period is sent exactly once and in the order it was applied, with no drop, repeat or partial word.
- R8: When a capture and a load strobe fall in the same bit-clock cycle, the shift registers take the word staged before that cycle. The newly captured word is sent in the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate, aligned to pix_clk |
| pwdn_n | input | 1 | Active-low power-down; clears all state and silences the lanes |
| pix_clk | input | 1 | Pixel clock, sampled as a level on bit_clk |
| edge_sel | input | 1 | 1 = capture on rising pixel edge, 0 = on falling edge |
| pix_data | input | 28 | Parallel pixel word |
| lane_out | output | 4 | Serial data lanes, bit L is lane L |
| clk_lane_out | output | 1 | Forwarded pixel-rate clock lane |

## Verification
A capture edge and the slot counter's load strobe can land in the same bit-clock cycle. When they do, the staging register is written while it is also being read. The bench provokes this by sweeping the pixel-clock phase against the power-down release over all seven offsets, for both edge settings, so one offset in each setting lines the capture up with the strobe. It judges the result by deserializing all four lanes with the clock-lane framing. The recovered word sequence must equal the applied sequence with nothing lost or repeated. Decoy data placed around the unselected edge must never appear.

// File: rtl/s7_pkg.sv
package s7_pkg;

  localparam int DEF_LANES = 4;
  localparam int DEF_SLICE = 7;
  localparam logic [DEF_SLICE-1:0] DEF_CLK_PATTERN = 7'b1100011;

  // next slot index of a modulo-slice counter
  function automatic int next_slot(input int cur, input int slice);
    return (cur >= slice - 1) ? 0 : cur + 1;
  endfunction

  // position of the lowest bit of a lane's group within the pixel word
  function automatic int slice_lsb(input int lane, input int slice);
    return lane * slice;
  endfunction

endpackage

// File: rtl/s7_slot_counter.sv
module s7_slot_counter #(
  parameter int SLICE = s7_pkg::DEF_SLICE
) (
  input  logic                       clk,
  input  logic                       pwdn_n,
  output logic [$clog2(SLICE)-1:0]   slot,
  output logic                       load_stb
);

  localparam int CW = $clog2(SLICE);
  localparam logic [CW-1:0] LAST = CW'(SLICE - 1);

  always_ff @(posedge clk or negedge pwdn_n) begin
    if (!pwdn_n) slot <= '0;
    else         slot <= CW'(s7_pkg::next_slot(int'(slot), SLICE));
  end

  // strobe on the final bit slot of each pixel period
  assign load_stb = (slot == LAST);

  p_slot_wrap_r3: assert property (@(posedge clk) disable iff (!pwdn_n)
    load_stb |=> slot == '0);

  p_slot_step_r3: assert property (@(posedge clk) disable iff (!pwdn_n)
    !load_stb |=> slot == $past(slot) + 1'b1);

endmodule

// File: rtl/s7_edge_stage.sv
module s7_edge_stage #(
  parameter int DW = s7_pkg::DEF_LANES * s7_pkg::DEF_SLICE
) (
  input  logic          clk,
  input  logic          pwdn_n,
  input  logic          pix_clk,
  input  logic          edge_sel,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] stage,
  output logic          have_word,
  output logic          cap_stb
);

  logic pix_q;
  logic primed;
  logic pix_rise;
  logic pix_fall;

  // primed stops a false edge on the first cycle after power-down release
  assign pix_rise = primed &  pix_clk & ~pix_q;
  assign pix_fall = primed & ~pix_clk &  pix_q;
  assign cap_stb  = edge_sel ? pix_rise : pix_fall;

  always_ff @(posedge clk or negedge pwdn_n) begin
    if (!pwdn_n) begin
      pix_q     <= 1'b0;
      primed    <= 1'b0;
      stage     <= '0;
      have_word <= 1'b0;
    end else begin
      pix_q  <= pix_clk;
      primed <= 1'b1;
      if (cap_stb) begin
        stage     <= din;
        have_word <= 1'b1;
      end
    end
  end

  p_capture_r2: assert property (@(posedge clk) disable iff (!pwdn_n)
    cap_stb |=> stage == $past(din));

  p_edge_level_r2: assert property (@(posedge clk) disable iff (!pwdn_n)
    cap_stb |-> pix_clk == edge_sel);

  p_hold_r7: assert property (@(posedge clk) disable iff (!pwdn_n)
    !cap_stb |=> $stable(stage));

endmodule

// File: rtl/s7_lane_shift.sv
module s7_lane_shift #(
  parameter int SLICE = s7_pkg::DEF_SLICE
) (
  input  logic             clk,
  input  logic             pwdn_n,
  input  logic             load,
  input  logic [SLICE-1:0] par,
  output logic             ser
);

  logic [SLICE-1:0] sh;

  always_ff @(posedge clk or negedge pwdn_n) begin
    if (!pwdn_n)   sh <= '0;
    else if (load) sh <= par;
    else           sh <= {sh[SLICE-2:0], 1'b0};
  end

  // highest bit of the slice leaves first
  assign ser = sh[SLICE-1];

  p_load_r8: assert property (@(posedge clk) disable iff (!pwdn_n)
    load |=> sh == $past(par));

  p_shift_r3: assert property (@(posedge clk) disable iff (!pwdn_n)
    !load |=> sh == {$past(sh[SLICE-2:0]), 1'b0});

endmodule

// File: rtl/s7_video_serializer.sv
module s7_video_serializer #(
  parameter int LANES = s7_pkg::DEF_LANES,
  parameter int SLICE = s7_pkg::DEF_SLICE,
  parameter logic [SLICE-1:0] CLK_PATTERN = s7_pkg::DEF_CLK_PATTERN,
  localparam int DW = LANES * SLICE
) (
  input  logic             bit_clk,
  input  logic             pwdn_n,
  input  logic             pix_clk,
  input  logic             edge_sel,
  input  logic [DW-1:0]    pix_data,
  output logic [LANES-1:0] lane_out,
  output logic             clk_lane_out
);

  localparam int CW = $clog2(SLICE);

  logic [CW-1:0]    slot;
  logic             load_stb;
  logic [DW-1:0]    stage;
  logic             have_word;
  logic             cap_stb;
  logic             active;
  logic [LANES-1:0] lane_ser;
  logic             clk_ser;
  logic [SLICE-1:0] clk_par;

  s7_slot_counter #(.SLICE(SLICE)) u_slot (
    .clk(bit_clk), .pwdn_n(pwdn_n), .slot(slot), .load_stb(load_stb)
  );

  s7_edge_stage #(.DW(DW)) u_stage (
    .clk(bit_clk), .pwdn_n(pwdn_n), .pix_clk(pix_clk), .edge_sel(edge_sel),
    .din(pix_data), .stage(stage), .have_word(have_word), .cap_stb(cap_stb)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLICE-1:0] par;
    assign par = have_word ? stage[s7_pkg::slice_lsb(l, SLICE) +: SLICE] : '0;

    s7_lane_shift #(.SLICE(SLICE)) u_sh (
      .clk(bit_clk), .pwdn_n(pwdn_n), .load(load_stb), .par(par), .ser(lane_ser[l])
    );

    assign lane_out[l] = pwdn_n & active & lane_ser[l];
  end

  assign clk_par = have_word ? CLK_PATTERN : '0;

  s7_lane_shift #(.SLICE(SLICE)) u_clk_sh (
    .clk(bit_clk), .pwdn_n(pwdn_n), .load(load_stb), .par(clk_par), .ser(clk_ser)
  );

  assign clk_lane_out = pwdn_n & active & clk_ser;

  // output opens only at a word boundary with a staged word
  always_ff @(posedge bit_clk or negedge pwdn_n) begin
    if (!pwdn_n)       active <= 1'b0;
    else if (load_stb) active <= have_word;
  end

  p_idle_r6: assert property (@(posedge bit_clk) disable iff (!pwdn_n)
    !active |-> (lane_out == '0 && !clk_lane_out));

  p_start_boundary_r6: assert property (@(posedge bit_clk) disable iff (!pwdn_n)
    $rose(active) |-> $past(load_stb));

  p_clk_first_hi_r4: assert property (@(posedge bit_clk) disable iff (!pwdn_n)
    (active && slot == '0) |-> clk_lane_out);

  p_clk_mid_lo_r4: assert property (@(posedge bit_clk) disable iff (!pwdn_n)
    (active && slot == CW'(2)) |-> !clk_lane_out);

  p_load_after_cap_r8: assert property (@(posedge bit_clk) disable iff (!pwdn_n)
    (load_stb && cap_stb) |=> have_word);

endmodule

// File: tb/sim_s7_video_serializer.sv
module sim_s7_video_serializer;

  localparam int LANES = 4;
  localparam int SLICE = 7;
  localparam int DW    = LANES * SLICE;
  localparam logic [SLICE-1:0] FRAME = 7'b1100011;

  logic             bit_clk  = 1'b0;
  logic             pwdn_n   = 1'b0;
  logic             pix_clk  = 1'b0;
  logic             edge_sel = 1'b1;
  logic [DW-1:0]    pix_data = '0;
  logic [LANES-1:0] lane_out;
  logic             clk_lane_out;

  s7_video_serializer u0 (
    .bit_clk(bit_clk), .pwdn_n(pwdn_n), .pix_clk(pix_clk), .edge_sel(edge_sel),
    .pix_data(pix_data), .lane_out(lane_out), .clk_lane_out(clk_lane_out)
  );

  always #5 bit_clk = ~bit_clk;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  int cap_ph = 0;
  int since_frame = -1;
  int widx = 0;
  int nwords = 0;
  int run_id = 0;
  bit drive_en = 1'b0;
  logic [SLICE-1:0] hist [LANES];
  logic [SLICE-1:0] chist = '0;
  logic [DW-1:0] rec[$];
  logic [DW-1:0] app[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int run, input int k);
    logic [31:0] x;
    x = (32'(run) * 32'd131 + 32'(k) + 32'd1) * 32'h9E3779B1;
    return x[31:4] | 28'h1;
  endfunction

  // one bit-clock cycle: sample lanes, deframe, then move pixel clock and data
  task automatic step();
    logic [DW-1:0] w;
    @(negedge bit_clk);
    for (int l = 0; l < LANES; l++) hist[l] = {hist[l][SLICE-2:0], lane_out[l]};
    chist = {chist[SLICE-2:0], clk_lane_out};
    if (since_frame >= 0) since_frame++;
    if (chist == FRAME) begin
      for (int l = 0; l < LANES; l++) w[l*SLICE +: SLICE] = hist[l];
      rec.push_back(w);
      if (since_frame >= 0)
        check(since_frame == SLICE, "R4", "frame spacing", since_frame, SLICE);
      since_frame = 0;
    end
    ph = (ph + 1) % SLICE;
    pix_clk = (ph < 4);
    if (drive_en) begin
      if (ph == (cap_ph + 5) % SLICE && widx < nwords) begin
        pix_data = word_of(run_id, widx);
        app.push_back(pix_data);
        widx++;
      end else if (ph == (cap_ph + 2) % SLICE && widx > 0 && widx < nwords) begin
        pix_data = ~pix_data;  // decoy around the unselected edge
      end
    end
  endtask

  task automatic power_down(input int n);
    pwdn_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      step();
      check(lane_out == '0 && !clk_lane_out, "R5", "lanes during power-down",
            {lane_out, clk_lane_out}, 0);
    end
  endtask

  task automatic run_stream(input bit es, input int offset, input int run, input int nw);
    int j;
    power_down(8);
    edge_sel = es;
    cap_ph = es ? 0 : 4;
    ph = offset;
    pix_clk = (ph < 4);
    rec.delete();
    app.delete();
    since_frame = -1;
    for (int l = 0; l < LANES; l++) hist[l] = '0;
    chist = '0;
    run_id = run;
    nwords = nw;
    widx = 0;
    drive_en = 1'b1;
    pwdn_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      check(lane_out == '0 && !clk_lane_out, "R6", "quiet after release",
            {lane_out, clk_lane_out}, 0);
    end
    while (widx < nwords) step();
    for (int i = 0; i < 4 * SLICE; i++) step();
    drive_en = 1'b0;
    // R1 R2 R3 R7 R8: recovered sequence equals applied sequence
    j = -1;
    for (int i = 0; i < rec.size(); i++)
      if (j < 0 && rec[i] == app[0]) j = i;
    check(j >= 0, "R7", "first word found", 32'(j), 0);
    if (j >= 0) begin
      for (int m = 0; m < app.size(); m++) begin
        if (j + m < rec.size())
          check(rec[j+m] == app[m], "R1 R2 R3 R7 R8", "recovered word",
                32'(rec[j+m]), 32'(app[m]));
        else
          check(1'b0, "R7", "word missing", 0, 32'(app[m]));
      end
    end
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) hist[l] = '0;
    for (int i = 0; i < 3; i++) begin
      step();
      check(lane_out == '0 && !clk_lane_out, "R5", "reset state",
            {lane_out, clk_lane_out}, 0);
    end
    for (int e = 1; e >= 0; e--)
      for (int off = 0; off < SLICE; off++)
        run_stream(e[0], off, e * SLICE + off, 12);
    power_down(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule